// File: doc/BRIEF.md
# 32-Source Interrupt Controller

This block collects up to 32 interrupt requests and presents them to a processor as two active-high request lines: a critical one and a non-critical one. Each source has its own active sense (high or low) and its own detection mode (level or edge). A detected request is latched into a pending-status register. Software clears it by writing a one to that bit. A request reaches an output only when its enable bit is set. A per-source steering bit picks which of the two outputs it drives.

Software talks to the block through a plain register port. There is one word address, a write strobe, write data, and a registered read-data bus. Picking which pending source to service is left to software, which scans the masked-status register.

Controllers can be chained. A child's output line is wired into one source input of a parent. Software services the child first and only then clears the parent's pending bit for that input.

Top module: `irq_ctrl32`

## Requirements
- R1: Source n (0..NSRC-1) uses bit NSRC-1-n of the `src_i` vector and of every register, so source 0 is bit 31 at the default size. After reset, status, enable and critical-select read 0, polarity reads all ones, trigger mode reads 0, and both request outputs are 0.
- R2: The status register sits at word address 0. Writing a 1 to a status bit clears that bit, and writing a 0 leaves the bit unchanged.
- R3: The masked-status register at address 5 reads as status AND enable. Writes to address 5 change no register.
- R4: A source whose trigger bit is 0 is level-sensitive. While its input is active, its status bit is set again in the cycle after a clear, so the bit stays pending until the input goes inactive.
- R5: A source whose trigger bit is 1 is edge-triggered. An inactive-to-active transition sets its status bit once. After a clear, the bit stays clear while the input is held active.
- R6: The polarity register sits at address 3. Bit value 1 means active-high or rising edge, and 0 means active-low or falling edge.
- R7: The critical-select register sits at address 2. An enabled pending source with select bit 1 drives `crit_irq_o`. With select bit 0 it drives `irq_o`.
- R8: Each output is a registered OR of status AND enable over the sources steered to it. A pending source that is not enabled drives neither output.
- R9: When a detected set and a software clear hit the same status bit in the same cycle, the bit ends set.
- R10: An input change reaches the status register on the third rising clock edge after it is applied, because of two synchronizer flops. It reaches the request outputs on the fourth edge.
- R11: The output of a child controller, wired to a level-mode source of a parent, pends in the parent. The parent bit clears only once the child has been serviced.
- R12: The enable (address 1), critical-select (2), polarity (3) and trigger-mode (4) registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Raw asynchronous request inputs, source n on bit NSRC-1-n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address for read and write |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Registered read data for the address of the previous cycle |
| irq_o | output | 1 | Non-critical request, active high |
| crit_irq_o | output | 1 | Critical request, active high |

## Verification
An input change appears in the status register three edges after it is applied, on the request outputs four edges after, and in `rdata_o` one edge after the address is presented. The bench drives every input just after a falling edge and samples on falling edges. It checks the output exactly at edges three and four after an input change, and it waits at least four cycles after any source or polarity change before clearing or reading. In the set-versus-clear test, the clear write is placed on the very edge at which the edge detector fires.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  localparam int OFF_STAT = 0;
  localparam int OFF_ENA  = 1;
  localparam int OFF_CRIT = 2;
  localparam int OFF_POL  = 3;
  localparam int OFF_TRIG = 4;
  localparam int OFF_MSK  = 5;
endpackage

// File: rtl/irq_sync_detect.sv
`timescale 1ns/1ps
module irq_sync_detect #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] pol_i,
  input  logic [NSRC-1:0] trig_i,
  output logic [NSRC-1:0] set_o
);
  logic [NSRC-1:0] meta_q, sync_q, act_q;
  logic [NSRC-1:0] act;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      act_q  <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      act_q  <= act;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_bit
      assign act[i]   = pol_i[i] ? sync_q[i] : ~sync_q[i];
      assign set_o[i] = trig_i[i] ? (act[i] & ~act_q[i]) : act[i];
    end
  endgenerate
endmodule

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs import irq_ctrl_pkg::*; #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   ena_o,
  output logic [NSRC-1:0]   crit_o,
  output logic [NSRC-1:0]   pol_o,
  output logic [NSRC-1:0]   trig_o,
  output logic [NSRC-1:0]   clr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ena_o  <= '0;
      crit_o <= '0;
      pol_o  <= '1;
      trig_o <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(OFF_ENA))  ena_o  <= wdata_i;
      if (addr_i == ADDR_W'(OFF_CRIT)) crit_o <= wdata_i;
      if (addr_i == ADDR_W'(OFF_POL))  pol_o  <= wdata_i;
      if (addr_i == ADDR_W'(OFF_TRIG)) trig_o <= wdata_i;
    end
  end

  assign clr_o = (wr_en_i && addr_i == ADDR_W'(OFF_STAT)) ? wdata_i : '0;
endmodule

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
module irq_status_reg #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] stat_o
);
  always_ff @(posedge clk) begin
    if (rst) stat_o <= '0;
    else     stat_o <= (stat_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_route_out.sv
`timescale 1ns/1ps
module irq_route_out #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] stat_i,
  input  logic [NSRC-1:0] ena_i,
  input  logic [NSRC-1:0] crit_i,
  output logic            irq_o,
  output logic            crit_irq_o
);
  logic [NSRC-1:0] live;
  assign live = stat_i & ena_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      crit_irq_o <= 1'b0;
    end else begin
      irq_o      <= |(live & ~crit_i);
      crit_irq_o <= |(live & crit_i);
    end
  end
endmodule

// File: rtl/irq_ctrl32.sv
`timescale 1ns/1ps
module irq_ctrl32 import irq_ctrl_pkg::*; #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              irq_o,
  output logic              crit_irq_o
);
  logic [NSRC-1:0] ena_q, crit_q, pol_q, trig_q, clr_vec, set_vec, stat_q;

  irq_cfg_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .ena_o(ena_q), .crit_o(crit_q), .pol_o(pol_q), .trig_o(trig_q), .clr_o(clr_vec)
  );

  irq_sync_detect #(.NSRC(NSRC)) u_det (
    .clk(clk), .rst(rst), .src_i(src_i), .pol_i(pol_q), .trig_i(trig_q), .set_o(set_vec)
  );

  irq_status_reg #(.NSRC(NSRC)) u_stat (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .stat_o(stat_q)
  );

  irq_route_out #(.NSRC(NSRC)) u_out (
    .clk(clk), .rst(rst), .stat_i(stat_q), .ena_i(ena_q), .crit_i(crit_q),
    .irq_o(irq_o), .crit_irq_o(crit_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      case (addr_i)
        ADDR_W'(OFF_STAT): rdata_o <= stat_q;
        ADDR_W'(OFF_ENA):  rdata_o <= ena_q;
        ADDR_W'(OFF_CRIT): rdata_o <= crit_q;
        ADDR_W'(OFF_POL):  rdata_o <= pol_q;
        ADDR_W'(OFF_TRIG): rdata_o <= trig_q;
        ADDR_W'(OFF_MSK):  rdata_o <= stat_q & ena_q;
        default:           rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_ctrl32_chk.sv
`timescale 1ns/1ps
module irq_ctrl32_chk import irq_ctrl_pkg::*; #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NSRC-1:0]   wdata_i,
  input logic [NSRC-1:0]   rdata_o,
  input logic [NSRC-1:0]   stat_q,
  input logic [NSRC-1:0]   ena_q,
  input logic [NSRC-1:0]   crit_q,
  input logic [NSRC-1:0]   set_vec,
  input logic              irq_o,
  input logic              crit_irq_o
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && ena_q == '0 && crit_q == '0));

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(OFF_STAT)) |=>
      ((stat_q & $past(wdata_i) & ~$past(set_vec)) == '0));

  assert_masked_read_R3: assert property (@(posedge clk) disable iff (rst)
    (addr_i == ADDR_W'(OFF_MSK)) |=> (rdata_o == $past(stat_q & ena_q)));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  assert_crit_route_R7: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ena_q & crit_q) != '0) |=> crit_irq_o);

  assert_out_idle_R8: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ena_q) == '0) |=> (!irq_o && !crit_irq_o));
endmodule

bind irq_ctrl32 irq_ctrl32_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .stat_q(stat_q), .ena_q(ena_q), .crit_q(crit_q),
  .set_vec(set_vec), .irq_o(irq_o), .crit_irq_o(crit_irq_o)
);

// File: tb/irq_ctrl32_test.sv
`timescale 1ns/1ps
module irq_ctrl32_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] h_src = '0, p_src, p_wd = '0, p_rd;
  logic [2:0]  p_addr = '0;
  logic        p_we = 1'b0, p_nc, p_cr;
  logic [31:0] c_src = '0, c_wd = '0, c_rd;
  logic [2:0]  c_addr = '0;
  logic        c_we = 1'b0, c_nc, c_cr;

  assign p_src = h_src | (c_nc ? 32'h0400_0000 : 32'h0);

  irq_ctrl32 uut (.clk(clk), .rst(rst), .src_i(p_src), .wr_en_i(p_we), .addr_i(p_addr),
    .wdata_i(p_wd), .rdata_o(p_rd), .irq_o(p_nc), .crit_irq_o(p_cr));
  irq_ctrl32 child (.clk(clk), .rst(rst), .src_i(c_src), .wr_en_i(c_we), .addr_i(c_addr),
    .wdata_i(c_wd), .rdata_o(c_rd), .irq_o(c_nc), .crit_irq_o(c_cr));

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); p_we = 1'b1; p_addr = a; p_wd = d;
    @(negedge clk); p_we = 1'b0;
  endtask
  task automatic cwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); c_we = 1'b1; c_addr = a; c_wd = d;
    @(negedge clk); c_we = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); p_addr = a;
    @(negedge clk); d = p_rd;
  endtask
  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] act_of(input logic [31:0] s, input logic [31:0] pol);
    return ~(s ^ pol);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, en, cr, pl, s, a;
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(3'd0, v); chk("R1 status", v, 32'h0);
    rd(3'd1, v); chk("R1 enable", v, 32'h0);
    rd(3'd2, v); chk("R1 crit", v, 32'h0);
    rd(3'd3, v); chk("R1 polarity", v, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R1 trigger", v, 32'h0);
    chk("R1 outputs", {30'b0, p_cr, p_nc}, 32'h0);

    // R10 latency, source 0 = bit 31, level, enabled, non-critical
    wr(3'd1, 32'h8000_0000);
    @(negedge clk); h_src[31] = 1'b1; p_addr = 3'd0;
    waitc(3); chk("R10 irq not yet at edge 3", {31'b0, p_nc}, 32'h0);
    chk("R10 rdata old at edge 3", p_rd & 32'h8000_0000, 32'h0);
    waitc(1); chk("R10 irq at edge 4", {31'b0, p_nc}, 32'h1);
    chk("R10 status visible", p_rd & 32'h8000_0000, 32'h8000_0000);

    // R4 level re-set while still active
    wr(3'd0, 32'h8000_0000);
    rd(3'd0, v); chk("R4 level stays pending", v & 32'h8000_0000, 32'h8000_0000);
    h_src[31] = 1'b0; waitc(4);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R4 clears after release", v, 32'h0);
    waitc(1); chk("R8 irq drops", {31'b0, p_nc}, 32'h0);

    // R5 edge mode on source 0
    wr(3'd4, 32'h8000_0000);
    wr(3'd0, 32'hFFFF_FFFF);
    h_src[31] = 1'b1; waitc(5);
    rd(3'd0, v); chk("R5 edge latched", v, 32'h8000_0000);
    wr(3'd0, 32'h8000_0000); waitc(3);
    rd(3'd0, v); chk("R5 no re-set while held", v, 32'h0);
    h_src[31] = 1'b0; waitc(5);
    rd(3'd0, v); chk("R5 falling edge ignored", v, 32'h0);

    // R2 writing zero keeps pending bits
    h_src[31] = 1'b1; waitc(5);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h0000_0001);
    rd(3'd0, v); chk("R2 zero write keeps", v, 32'h8000_0000);

    // R3 masked status, write ignored
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R3 status untouched", v, 32'h8000_0000);
    rd(3'd1, v); chk("R3 enable untouched", v, 32'h8000_0000);
    rd(3'd5, v); chk("R3 masked", v, 32'h8000_0000);

    // R8 disabled pending drives nothing
    wr(3'd1, 32'h0); waitc(2);
    chk("R8 disabled no irq", {30'b0, p_cr, p_nc}, 32'h0);
    rd(3'd5, v); chk("R3 masked when disabled", v, 32'h0);

    // R7 critical steering
    wr(3'd2, 32'h8000_0000); wr(3'd1, 32'h8000_0000); waitc(2);
    chk("R7 critical routed", {30'b0, p_cr, p_nc}, 32'h2);
    wr(3'd2, 32'h0); waitc(2);
    chk("R7 non-critical routed", {30'b0, p_cr, p_nc}, 32'h1);
    wr(3'd0, 32'h8000_0000); h_src[31] = 1'b0;

    // R6 active-low level on source 1 (bit 30)
    wr(3'd3, 32'hBFFF_FFFF);
    @(negedge clk); h_src[30] = 1'b1; waitc(4);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R6 high is inactive", v & 32'h4000_0000, 32'h0);
    h_src[30] = 1'b0; waitc(4);
    rd(3'd0, v); chk("R6 low is active", v & 32'h4000_0000, 32'h4000_0000);

    // R9 set and clear in same cycle, source 2 (bit 29) rising edge
    wr(3'd4, 32'h2000_0000);
    waitc(4); wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk); h_src[29] = 1'b1;
    @(negedge clk);
    @(negedge clk); p_we = 1'b1; p_addr = 3'd0; p_wd = 32'h2000_0000;
    @(negedge clk); p_we = 1'b0;
    rd(3'd0, v); chk("R9 set wins", v & 32'h2000_0000, 32'h2000_0000);
    wr(3'd0, 32'h2000_0000);
    rd(3'd0, v); chk("R9 later clear works", v & 32'h2000_0000, 32'h0);
    h_src = '0;

    // R12 readback
    wr(3'd1, 32'h1234_5678); rd(3'd1, v); chk("R12 enable", v, 32'h1234_5678);
    wr(3'd2, 32'hA5A5_0F0F); rd(3'd2, v); chk("R12 crit", v, 32'hA5A5_0F0F);
    wr(3'd3, 32'h0F0F_A5A5); rd(3'd3, v); chk("R12 polarity", v, 32'h0F0F_A5A5);
    wr(3'd4, 32'hCAFE_0001); rd(3'd4, v); chk("R12 trigger", v, 32'hCAFE_0001);

    // R11 cascade: child source 0 into parent source 5 (bit 26)
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'h0); wr(3'd2, 32'h0);
    wr(3'd1, 32'h0400_0000); waitc(4); wr(3'd0, 32'hFFFF_FFFF);
    cwr(3'd1, 32'h8000_0000);
    c_src[31] = 1'b1; waitc(10);
    chk("R11 parent irq from child", {31'b0, p_nc}, 32'h1);
    rd(3'd0, v); chk("R11 parent pending", v, 32'h0400_0000);
    c_src[31] = 1'b0; waitc(4);
    cwr(3'd0, 32'hFFFF_FFFF); waitc(6);
    wr(3'd0, 32'h0400_0000); waitc(2);
    rd(3'd0, v); chk("R11 parent cleared", v, 32'h0);
    chk("R11 parent irq low", {31'b0, p_nc}, 32'h0);
    cwr(3'd1, 32'h0);

    // Random level-mode mix: R4 R6 R7 R8
    wr(3'd4, 32'h0);
    for (int it = 0; it < 16; it++) begin
      en = $urandom; cr = $urandom; pl = $urandom; s = $urandom & 32'hFBFF_FFFF;
      wr(3'd1, en); wr(3'd2, cr); wr(3'd3, pl);
      h_src = s; waitc(4);
      wr(3'd0, 32'hFFFF_FFFF); waitc(4);
      a = act_of(s, pl) & 32'hFBFF_FFFF;
      a = a | (pl[26] ? 32'h0 : 32'h0400_0000);
      rd(3'd0, v); chk("R4 R6 random status", v, a);
      rd(3'd5, v); chk("R3 random masked", v, a & en);
      chk("R7 random crit", {31'b0, p_cr}, {31'b0, |(a & en & cr)});
      chk("R8 random noncrit", {31'b0, p_nc}, {31'b0, |(a & en & ~cr)});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule